// File: doc/BRIEF.md
# Processor State and Control Register with Interrupt Gating

This block holds the processor's privilege, interrupt-enable, power-wait and feature-enable bits in one 32-bit word. Software writes the whole word through a move-to port and reads it through a move-from port. A narrow update port changes only the external-enable bit and leaves every other bit alone. Taking an interrupt copies the word to a save register and forces a safe state. Returning from the interrupt reloads the saved copy.

The stored bits drive gating logic that sits between the interrupt sources and the exception unit. The critical-enable bit masks the critical-input and watchdog requests, and machine check always passes. The external-enable bit masks the external, decrementer, fixed-interval-timer and performance-monitor requests. The wait bit gates three power-management request lines. The block also flags two faults: cache locking attempted from user mode, and upper-half vector instructions used while that unit is disabled.

Bit positions use big-endian numbering 32..63, so architectural bit n sits at word index 63−n. The six implemented positions are listed in R2.

Top module: `cpu_state_ctl`

## Requirements
- R1: While `rst` is high, the word is cleared at every clock edge: `rd_data` reads 0x00000000, which means supervisor mode with every interrupt class disabled.
- R2: Only six word indices are stored: user-lock enable at index 26 (0x04000000), vector-unit enable at index 25 (0x02000000), wait at index 18 (0x00040000), critical enable at index 17 (0x00020000), external enable at index 15 (0x00008000) and user mode at index 14 (0x00004000). Every other index reads zero, and values written to it are ignored.
- R3: In supervisor mode, a `mt_valid` cycle loads `mt_data` (masked per R2) at the next edge. `rd_data` always shows the current word.
- R4: In supervisor mode, an `ee_wr_valid` cycle sets index 15 to `ee_wr_val` and leaves the other bits unchanged. If `mt_valid` is high in the same cycle, the move-to wins.
- R5: While user mode is set, `priv_fault` is high in any cycle where `mt_valid` or `ee_wr_valid` is high, and neither write changes the word.
- R6: `crit_out` and `wdog_out` equal their requests ANDed with the critical-enable bit. `mchk_out` always equals `mchk_req`.
- R7: `ext_out`, `dec_out`, `fit_out` and `pmon_out` equal their requests ANDed with the external-enable bit.
- R8: An `irq_enter` cycle copies the current word into the save register. It also clears the wait, external-enable and user-mode bits and keeps the others. It takes priority over `irq_return` and over both writes in the same cycle.
- R9: An `irq_return` cycle without `irq_enter` reloads the word from the save register.
- R10: `pm_doze`, `pm_nap` and `pm_sleep` each equal the wait bit ANDed with the matching configuration input. They therefore drop while an interrupt is being handled and come back after the return.
- R11: When user mode is set and user-lock enable is clear, a data or instruction lock operation raises `lock_fault` together with the matching syndrome flag. No lock fault is raised otherwise.
- R12: `vec_unavail` is high when `upper_op` is high and the vector-unit enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_valid | input | 1 | Move-to request |
| mt_data | input | 32 | Move-to value |
| ee_wr_valid | input | 1 | External-enable single-bit write request |
| ee_wr_val | input | 1 | New external-enable value |
| irq_enter | input | 1 | Interrupt entry pulse |
| irq_return | input | 1 | Return-from-interrupt pulse |
| crit_req | input | 1 | Critical input request |
| wdog_req | input | 1 | Watchdog request |
| mchk_req | input | 1 | Machine check request |
| ext_req | input | 1 | External input request |
| dec_req | input | 1 | Decrementer request |
| fit_req | input | 1 | Fixed-interval timer request |
| pmon_req | input | 1 | Performance monitor request |
| cfg_doze | input | 1 | Doze configuration |
| cfg_nap | input | 1 | Nap configuration |
| cfg_sleep | input | 1 | Sleep configuration |
| lock_op_d | input | 1 | Data cache lock operation |
| lock_op_i | input | 1 | Instruction cache lock operation |
| upper_op | input | 1 | Instruction uses upper register half |
| rd_data | output | 32 | Move-from value (current word) |
| priv_fault | output | 1 | Privileged write attempted in user mode |
| crit_out | output | 1 | Gated critical request |
| wdog_out | output | 1 | Gated watchdog request |
| mchk_out | output | 1 | Machine check request (never masked) |
| ext_out | output | 1 | Gated external request |
| dec_out | output | 1 | Gated decrementer request |
| fit_out | output | 1 | Gated fixed-interval request |
| pmon_out | output | 1 | Gated performance monitor request |
| pm_doze | output | 1 | Doze request to power control |
| pm_nap | output | 1 | Nap request to power control |
| pm_sleep | output | 1 | Sleep request to power control |
| lock_fault | output | 1 | Cache-lock storage fault |
| lock_syn_d | output | 1 | Data lock syndrome |
| lock_syn_i | output | 1 | Instruction lock syndrome |
| vec_unavail | output | 1 | Vector unit unavailable request |

## Verification
The assertions check the following on every cycle:
- Unimplemented indices read zero.
- No gated request or power line is ever high without its enable bit.
- Machine check is never masked.
- The word stays frozen across user-mode write attempts.
- Entry clears the wait, external-enable and user bits.
- A return right after an entry gives back the pre-entry word.

Only the bench's scenarios can show the rest. These are the priority when entry, return, move-to and single-bit writes collide in one cycle, a save register surviving a long handler that rewrites the word, and the reset value.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;

    localparam int WORD_W = 32;

    // Word index = 63 - architectural bit number
    localparam int IDX_ULOCK = 26;
    localparam int IDX_VEC   = 25;
    localparam int IDX_WAIT  = 18;
    localparam int IDX_CRIT  = 17;
    localparam int IDX_EXT   = 15;
    localparam int IDX_USER  = 14;

    localparam logic [WORD_W-1:0] IMPL_MASK =
        (WORD_W'(1) << IDX_ULOCK) | (WORD_W'(1) << IDX_VEC)  |
        (WORD_W'(1) << IDX_WAIT)  | (WORD_W'(1) << IDX_CRIT) |
        (WORD_W'(1) << IDX_EXT)   | (WORD_W'(1) << IDX_USER);

    localparam logic [WORD_W-1:0] ENTER_CLR_MASK =
        (WORD_W'(1) << IDX_WAIT) | (WORD_W'(1) << IDX_EXT) |
        (WORD_W'(1) << IDX_USER);

    typedef struct packed {
        logic ulock;
        logic vec;
        logic wait_en;
        logic crit;
        logic ext;
        logic user;
    } state_t;

    typedef struct packed {
        logic crit;
        logic wdog;
        logic mchk;
        logic ext;
        logic dec;
        logic fit;
        logic pmon;
    } irq_vec_t;

    typedef struct packed {
        logic doze;
        logic nap;
        logic sleep;
    } pm_vec_t;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_ENTER,
        UPD_RETURN,
        UPD_LOAD,
        UPD_EXT
    } upd_e;

    function automatic state_t word_to_state(logic [WORD_W-1:0] w);
        state_t s;
        s.ulock   = w[IDX_ULOCK];
        s.vec     = w[IDX_VEC];
        s.wait_en = w[IDX_WAIT];
        s.crit    = w[IDX_CRIT];
        s.ext     = w[IDX_EXT];
        s.user    = w[IDX_USER];
        return s;
    endfunction

endpackage

// File: rtl/cpu_state_store.sv
module cpu_state_store
    import cpu_state_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mt_valid,
    input  logic [WORD_W-1:0] mt_data,
    input  logic              ee_wr_valid,
    input  logic              ee_wr_val,
    input  logic              irq_enter,
    input  logic              irq_return,
    output logic [WORD_W-1:0] cur_word,
    output logic              priv_fault
);

    logic [WORD_W-1:0] save_word;
    logic [WORD_W-1:0] next_word;
    logic              in_user;
    upd_e              upd_sel;

    assign in_user    = cur_word[IDX_USER];
    assign priv_fault = in_user & (mt_valid | ee_wr_valid);

    // Priority: entry, return, full load, single-bit write
    always_comb begin
        if (irq_enter)                    upd_sel = UPD_ENTER;
        else if (irq_return)              upd_sel = UPD_RETURN;
        else if (mt_valid && !in_user)    upd_sel = UPD_LOAD;
        else if (ee_wr_valid && !in_user) upd_sel = UPD_EXT;
        else                              upd_sel = UPD_HOLD;
    end

    always_comb begin
        next_word = cur_word;
        case (upd_sel)
            UPD_ENTER:  next_word = cur_word & ~ENTER_CLR_MASK;
            UPD_RETURN: next_word = save_word;
            UPD_LOAD:   next_word = mt_data & IMPL_MASK;
            UPD_EXT:    next_word[IDX_EXT] = ee_wr_val;
            default:    next_word = cur_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word  <= '0;
            save_word <= '0;
        end else begin
            cur_word <= next_word & IMPL_MASK;
            if (upd_sel == UPD_ENTER)
                save_word <= cur_word;
        end
    end

endmodule

// File: rtl/cpu_irq_mask.sv
module cpu_irq_mask
    import cpu_state_pkg::*;
(
    input  state_t   st,
    input  irq_vec_t req,
    output irq_vec_t gated
);

    always_comb begin
        gated.crit = req.crit & st.crit;
        gated.wdog = req.wdog & st.crit;
        gated.mchk = req.mchk;
        gated.ext  = req.ext  & st.ext;
        gated.dec  = req.dec  & st.ext;
        gated.fit  = req.fit  & st.ext;
        gated.pmon = req.pmon & st.ext;
    end

endmodule

// File: rtl/cpu_pm_fault.sv
module cpu_pm_fault
    import cpu_state_pkg::*;
(
    input  state_t  st,
    input  pm_vec_t cfg,
    input  logic    lock_op_d,
    input  logic    lock_op_i,
    input  logic    upper_op,
    output pm_vec_t pm,
    output logic    lock_fault,
    output logic    lock_syn_d,
    output logic    lock_syn_i,
    output logic    vec_unavail
);

    logic lock_barred;

    always_comb begin
        pm.doze  = cfg.doze  & st.wait_en;
        pm.nap   = cfg.nap   & st.wait_en;
        pm.sleep = cfg.sleep & st.wait_en;
    end

    assign lock_barred = st.user & ~st.ulock;
    assign lock_syn_d  = lock_barred & lock_op_d;
    assign lock_syn_i  = lock_barred & lock_op_i;
    assign lock_fault  = lock_syn_d | lock_syn_i;
    assign vec_unavail = upper_op & ~st.vec;

endmodule

// File: rtl/cpu_state_ctl.sv
module cpu_state_ctl
    import cpu_state_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mt_valid,
    input  logic [31:0] mt_data,
    input  logic        ee_wr_valid,
    input  logic        ee_wr_val,
    input  logic        irq_enter,
    input  logic        irq_return,
    input  logic        crit_req,
    input  logic        wdog_req,
    input  logic        mchk_req,
    input  logic        ext_req,
    input  logic        dec_req,
    input  logic        fit_req,
    input  logic        pmon_req,
    input  logic        cfg_doze,
    input  logic        cfg_nap,
    input  logic        cfg_sleep,
    input  logic        lock_op_d,
    input  logic        lock_op_i,
    input  logic        upper_op,
    output logic [31:0] rd_data,
    output logic        priv_fault,
    output logic        crit_out,
    output logic        wdog_out,
    output logic        mchk_out,
    output logic        ext_out,
    output logic        dec_out,
    output logic        fit_out,
    output logic        pmon_out,
    output logic        pm_doze,
    output logic        pm_nap,
    output logic        pm_sleep,
    output logic        lock_fault,
    output logic        lock_syn_d,
    output logic        lock_syn_i,
    output logic        vec_unavail
);

    logic [WORD_W-1:0] cur_word;
    state_t            st;
    irq_vec_t          req_v;
    irq_vec_t          gated_v;
    pm_vec_t           cfg_v;
    pm_vec_t           pm_v;

    cpu_state_store u_store (
        .clk        (clk),
        .rst        (rst),
        .mt_valid   (mt_valid),
        .mt_data    (mt_data),
        .ee_wr_valid(ee_wr_valid),
        .ee_wr_val  (ee_wr_val),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .cur_word   (cur_word),
        .priv_fault (priv_fault)
    );

    assign st      = word_to_state(cur_word);
    assign rd_data = cur_word;

    assign req_v = '{crit: crit_req, wdog: wdog_req, mchk: mchk_req,
                     ext: ext_req, dec: dec_req, fit: fit_req, pmon: pmon_req};

    cpu_irq_mask u_mask (
        .st   (st),
        .req  (req_v),
        .gated(gated_v)
    );

    assign crit_out = gated_v.crit;
    assign wdog_out = gated_v.wdog;
    assign mchk_out = gated_v.mchk;
    assign ext_out  = gated_v.ext;
    assign dec_out  = gated_v.dec;
    assign fit_out  = gated_v.fit;
    assign pmon_out = gated_v.pmon;

    assign cfg_v = '{doze: cfg_doze, nap: cfg_nap, sleep: cfg_sleep};

    cpu_pm_fault u_pmf (
        .st         (st),
        .cfg        (cfg_v),
        .lock_op_d  (lock_op_d),
        .lock_op_i  (lock_op_i),
        .upper_op   (upper_op),
        .pm         (pm_v),
        .lock_fault (lock_fault),
        .lock_syn_d (lock_syn_d),
        .lock_syn_i (lock_syn_i),
        .vec_unavail(vec_unavail)
    );

    assign pm_doze  = pm_v.doze;
    assign pm_nap   = pm_v.nap;
    assign pm_sleep = pm_v.sleep;

endmodule

// File: rtl/cpu_state_ctl_chk.sv
module cpu_state_ctl_chk
    import cpu_state_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mt_valid,
    input logic        ee_wr_valid,
    input logic        irq_enter,
    input logic        irq_return,
    input logic        crit_req,
    input logic        wdog_req,
    input logic        mchk_req,
    input logic        ext_req,
    input logic        cfg_doze,
    input logic        cfg_nap,
    input logic        cfg_sleep,
    input logic [31:0] rd_data,
    input logic        priv_fault,
    input logic        crit_out,
    input logic        wdog_out,
    input logic        mchk_out,
    input logic        ext_out,
    input logic        pm_doze,
    input logic        pm_nap,
    input logic        pm_sleep
);

    // R2
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~IMPL_MASK) == '0);

    // R5
    user_write_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_fault && !irq_enter && !irq_return) |=> $stable(rd_data));

    // R5
    priv_flag_chk: assert property (@(posedge clk) disable iff (rst)
        priv_fault |-> (rd_data[IDX_USER] && (mt_valid || ee_wr_valid)));

    // R6
    crit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (crit_out || wdog_out) |-> (rd_data[IDX_CRIT] && (crit_req || wdog_req)));

    // R6
    mchk_pass_chk: assert property (@(posedge clk) disable iff (rst)
        mchk_out == mchk_req);

    // R7
    ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ext_out |-> (rd_data[IDX_EXT] && ext_req));

    // R8
    enter_clears_chk: assert property (@(posedge clk) disable iff (rst)
        irq_enter |=> (!rd_data[IDX_WAIT] && !rd_data[IDX_EXT] && !rd_data[IDX_USER]));

    // R9
    quick_return_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_return && !irq_enter && $past(irq_enter) && !$past(rst))
        |=> rd_data == $past(rd_data, 2));

    // R10
    pm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pm_doze || pm_nap || pm_sleep) |->
        (rd_data[IDX_WAIT] && (pm_doze <= cfg_doze) && (pm_nap <= cfg_nap)
         && (pm_sleep <= cfg_sleep)));

endmodule

bind cpu_state_ctl cpu_state_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mt_valid   (mt_valid),
    .ee_wr_valid(ee_wr_valid),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .crit_req   (crit_req),
    .wdog_req   (wdog_req),
    .mchk_req   (mchk_req),
    .ext_req    (ext_req),
    .cfg_doze   (cfg_doze),
    .cfg_nap    (cfg_nap),
    .cfg_sleep  (cfg_sleep),
    .rd_data    (rd_data),
    .priv_fault (priv_fault),
    .crit_out   (crit_out),
    .wdog_out   (wdog_out),
    .mchk_out   (mchk_out),
    .ext_out    (ext_out),
    .pm_doze    (pm_doze),
    .pm_nap     (pm_nap),
    .pm_sleep   (pm_sleep)
);

// File: tb/cpu_state_ctl_bench.sv
module cpu_state_ctl_bench;

    localparam logic [31:0] MASK    = 32'h0606_C000;
    localparam logic [31:0] CLR_ENT = 32'h0004_C000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mt_valid = 0, ee_wr_valid = 0, ee_wr_val = 0;
    logic [31:0] mt_data = '0;
    logic irq_enter = 0, irq_return = 0;
    logic crit_req = 0, wdog_req = 0, mchk_req = 0, ext_req = 0;
    logic dec_req = 0, fit_req = 0, pmon_req = 0;
    logic cfg_doze = 0, cfg_nap = 0, cfg_sleep = 0;
    logic lock_op_d = 0, lock_op_i = 0, upper_op = 0;
    logic [31:0] rd_data;
    logic priv_fault, crit_out, wdog_out, mchk_out, ext_out, dec_out, fit_out, pmon_out;
    logic pm_doze, pm_nap, pm_sleep, lock_fault, lock_syn_d, lock_syn_i, vec_unavail;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [31:0] m_word = '0;
    logic [31:0] m_save = '0;

    always #5 clk = ~clk;

    cpu_state_ctl u_cpu_state_ctl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare outputs against the model, then advance one clock
    task automatic tick();
        logic u, ce, ee, wt;
        #2;
        u  = m_word[14]; ee = m_word[15]; ce = m_word[17]; wt = m_word[18];
        chk("R3 rd_data", rd_data, m_word);
        chk("R5 priv_fault", 32'(priv_fault), 32'(u & (mt_valid | ee_wr_valid)));
        chk("R6 crit/wdog/mchk", {29'd0, crit_out, wdog_out, mchk_out},
            {29'd0, crit_req & ce, wdog_req & ce, mchk_req});
        chk("R7 ext group", {28'd0, ext_out, dec_out, fit_out, pmon_out},
            {28'd0, ext_req & ee, dec_req & ee, fit_req & ee, pmon_req & ee});
        chk("R10 power lines", {29'd0, pm_doze, pm_nap, pm_sleep},
            {29'd0, cfg_doze & wt, cfg_nap & wt, cfg_sleep & wt});
        chk("R11 lock fault", {29'd0, lock_fault, lock_syn_d, lock_syn_i},
            {29'd0, (u & ~m_word[26]) & (lock_op_d | lock_op_i),
             u & ~m_word[26] & lock_op_d, u & ~m_word[26] & lock_op_i});
        chk("R12 vec_unavail", 32'(vec_unavail), 32'(upper_op & ~m_word[25]));
        @(posedge clk);
        if (rst) begin
            m_word = '0; m_save = '0;
        end else if (irq_enter) begin
            m_save = m_word; m_word = m_word & ~CLR_ENT;
        end else if (irq_return) begin
            m_word = m_save;
        end else if (mt_valid && !u) begin
            m_word = mt_data & MASK;
        end else if (ee_wr_valid && !u) begin
            m_word[15] = ee_wr_val;
        end
        cycles++;
        @(negedge clk);
    endtask

    task automatic idle();
        mt_valid = 0; ee_wr_valid = 0; irq_enter = 0; irq_return = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired: actual=running expected=done");
        summary();
    end

    initial begin
        @(negedge clk);
        mt_valid = 1; mt_data = 32'hFFFF_FFFF;   // ignored under reset
        tick(); tick();
        idle();
        chk("R1 reset value", rd_data, 32'h0);
        rst = 0;
        tick();
        // R2/R3: full load of all ones keeps only implemented bits
        mt_valid = 1; mt_data = 32'hFFFF_FFFF & ~32'h0000_4000; tick(); idle();
        chk("R2 masked load", rd_data, 32'h0602_8000 | 32'h0004_0000);
        // Gating with all requests and configs high
        {crit_req, wdog_req, mchk_req, ext_req, dec_req, fit_req, pmon_req} = '1;
        {cfg_doze, cfg_nap, cfg_sleep} = 3'b101; upper_op = 1; tick();
        // R4: single-bit clear, then move-to wins over bit write
        ee_wr_valid = 1; ee_wr_val = 0; tick(); idle();
        chk("R4 ext cleared only", rd_data, 32'h0606_4000 & ~32'h0000_4000);
        ee_wr_valid = 1; ee_wr_val = 1; mt_valid = 1; mt_data = 32'h0000_0000; tick(); idle();
        chk("R4 move-to priority", rd_data, 32'h0);
        tick();
        // Enter user mode with ext and wait set, lock enable clear
        mt_valid = 1; mt_data = 32'h0004_C000; tick(); idle();
        lock_op_d = 1; tick(); lock_op_d = 0; lock_op_i = 1; tick(); lock_op_i = 0;
        // R5: writes from user mode blocked
        mt_valid = 1; mt_data = 32'h0; tick(); idle();
        ee_wr_valid = 1; ee_wr_val = 0; tick(); idle();
        chk("R5 user write ignored", rd_data, 32'h0004_C000);
        // R8: entry beats return and writes
        irq_enter = 1; irq_return = 1; mt_valid = 1; mt_data = 32'h0602_0000; tick(); idle();
        chk("R8 entry clears", rd_data, 32'h0);
        // Handler rewrites word, then R9 return restores
        mt_valid = 1; mt_data = 32'h0602_0000; tick(); idle();
        tick();
        irq_return = 1; tick(); idle();
        chk("R9 restored", rd_data, 32'h0004_C000);
        // Quick enter/return pair
        irq_enter = 1; tick(); idle(); irq_return = 1; tick(); idle();
        chk("R9 quick return", rd_data, 32'h0004_C000);
        // Leave user mode via interrupt, then random phase
        irq_enter = 1; tick(); idle();
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            mt_valid = (r[3:0] == 0); ee_wr_valid = (r[7:4] < 3); ee_wr_val = r[8];
            irq_enter = (r[12:9] == 0); irq_return = (r[16:13] == 0);
            mt_data = $urandom;
            {crit_req, wdog_req, mchk_req, ext_req, dec_req, fit_req, pmon_req} = r[23:17];
            {cfg_doze, cfg_nap, cfg_sleep, lock_op_d, lock_op_i, upper_op} = r[29:24];
            tick();
        end
        idle();
        tick();
        summary();
    end

endmodule